// File: doc/BRIEF.md
# Banked Data Memory with Indirect Pointers

This block is the byte-wide data store of a small microcontroller core. A single address bus covers the whole data space. The low part holds special-function bytes and reserved holes. The high part is general-purpose RAM. Two fixed addresses have no storage of their own. An access to either one is passed on to the byte selected by one of two pointer registers. Those pointers are themselves bytes in the same space.

The accumulator is an ordinary mapped byte. The core sees its value on a dedicated port, and it sees both pointers the same way. The core can write a whole byte, or set or clear a single bit of any writable byte. Reads are combinational. The resolved target address is exported so that the peripheral side can return a read-only mask for that byte. Bits flagged in the mask keep their value through any write.

Access is a plain single-cycle memory port with no handshake: every cycle the address is decoded, and any strobe that is high is committed at the next rising edge.

Top module: `dm_banked_mem`

## Requirements
- R1: Address 00H forwards every access to the byte at the address held in pointer 0, which is stored at 01H. Address 02H does the same through pointer 1, stored at 03H.
- R2: When a pointer holds 00H or 02H, a read through it returns 00H. A write or bit operation through it changes no byte.
- R3: The accumulator lives at 05H, is read and written like any byte, and its value is always visible on `acc`.
- R4: A location below the RAM base that is not in the implemented-register map reads 00H, and writes or bit operations to it change nothing.
- R5: Locations from the RAM base (default 40H) to FFH hold 192 bytes that read back what was last written.
- R6: `bit_set` or `bit_clr` forces bit `bit_idx` (0 = LSB) of the target byte to 1 or 0 and leaves its other bits unchanged.
- R7: A bit operation addressed to 00H or 02H acts on the byte that the matching pointer selects.
- R8: `rdata` follows the address with no clock in between. A write becomes visible only after the next rising edge of `clk`.
- R9: While `rst_n` is low, both pointers, the accumulator and every implemented special-function byte become 00H.
- R10: A 1 in bit i of `ro_mask` keeps bit i of the target byte at its old value during a write or a bit operation. Bits with a 0 in the mask are updated.
- R11: When several strobes are high in the same cycle, `we` wins over `bit_set`, and `bit_set` wins over `bit_clr`.
- R12: Pointers are full 8-bit values, so an indirect access can reach any byte. This includes the accumulator and the pointer registers themselves.
- R13: `eff_addr` shows the address actually reached: the pointer value for 00H and 02H, otherwise `addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Data-space address |
| wdata | input | 8 | Byte to write |
| we | input | 1 | Byte write strobe |
| bit_set | input | 1 | Set bit `bit_idx` of the target |
| bit_clr | input | 1 | Clear bit `bit_idx` of the target |
| bit_idx | input | 3 | Bit number for bit operations |
| ro_mask | input | 8 | Read-only bits of the target byte |
| rdata | output | 8 | Value of the target byte |
| eff_addr | output | 8 | Resolved target address |
| ptr0 | output | 8 | Pointer 0 contents |
| ptr1 | output | 8 | Pointer 1 contents |
| acc | output | 8 | Accumulator contents |

## Verification
The bench uses the default parameters. These are an 8-bit data path, a RAM base of 40H, and a register map that implements 04H–1BH and 20H–27H. With these values the reserved holes at 1CH–1FH and 28H–3FH can be tested, as can the RAM end points 40H and FFH. Both pointer chains are tested, including a pointer that targets itself, the accumulator, or an indirect address. Read-only masking and strobe priority are applied to the accumulator and to RAM, and the results are read back through the data port.

// File: rtl/dm_pkg.sv
package dm_pkg;
  typedef enum logic [1:0] {
    RG_NULL = 2'd0,
    RG_RSV  = 2'd1,
    RG_SFR  = 2'd2,
    RG_GPR  = 2'd3
  } region_e;

  localparam int unsigned IND0_A = 0;
  localparam int unsigned PTR0_A = 1;
  localparam int unsigned IND1_A = 2;
  localparam int unsigned PTR1_A = 3;
  localparam int unsigned ACC_A  = 5;
endpackage

// File: rtl/dm_addr_resolve.sv
module dm_addr_resolve
  import dm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GP_BASE = 64,
  parameter logic [GP_BASE-1:0] IMPL = '0
) (
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] ptr0,
  input  logic [DATA_W-1:0] ptr1,
  output logic [DATA_W-1:0] eff,
  output region_e           region
);
  localparam int unsigned ADDR_W = DATA_W;
  localparam int unsigned SFR_AW = $clog2(GP_BASE);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(GP_BASE);

  always_comb begin
    if (addr == ADDR_W'(IND0_A))      eff = ptr0;
    else if (addr == ADDR_W'(IND1_A)) eff = ptr1;
    else                              eff = addr;

    if (eff == ADDR_W'(IND0_A) || eff == ADDR_W'(IND1_A))
      region = RG_NULL;
    else if (eff < BASE_A)
      region = IMPL[eff[SFR_AW-1:0]] ? RG_SFR : RG_RSV;
    else
      region = RG_GPR;
  end
endmodule

// File: rtl/dm_sfr_file.sv
module dm_sfr_file
  import dm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GP_BASE = 64,
  parameter logic [GP_BASE-1:0] IMPL = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(GP_BASE)-1:0] rd_idx,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       wr_en,
  input  logic [$clog2(GP_BASE)-1:0] wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          ptr0,
  output logic [DATA_W-1:0]          ptr1,
  output logic [DATA_W-1:0]          acc
);
  localparam int unsigned SFR_AW = $clog2(GP_BASE);

  logic [DATA_W-1:0] slot [GP_BASE];

  for (genvar i = 0; i < GP_BASE; i++) begin : g_slot
    if (IMPL[i]) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   q <= '0;
        else if (wr_en && wr_idx == SFR_AW'(i))       q <= wr_data;
      end
      assign slot[i] = q;
    end else begin : g_hole
      assign slot[i] = '0;
    end
  end

  assign rd_data = slot[rd_idx];
  assign ptr0    = slot[PTR0_A];
  assign ptr1    = slot[PTR1_A];
  assign acc     = slot[ACC_A];

  // R12: a pointer changes only when its own slot is written
  a_r12_ptr0_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_idx == SFR_AW'(PTR0_A)) |=> $stable(ptr0));
  a_r12_ptr1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_idx == SFR_AW'(PTR1_A)) |=> $stable(ptr1));
  // R3: accumulator takes the committed byte
  a_r3_acc_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == SFR_AW'(ACC_A)) |=> acc == $past(wr_data));
endmodule

// File: rtl/dm_gp_ram.sv
module dm_gp_ram #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 192
) (
  input  logic                     clk,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DATA_W-1:0]        wr_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && int'(wr_idx) < DEPTH) mem[wr_idx] <= wr_data;
  end

  assign rd_data = (int'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;
endmodule

// File: rtl/dm_banked_mem.sv
module dm_banked_mem
  import dm_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned GP_BASE = 64,
  parameter logic [GP_BASE-1:0] SFR_MAP = 64'h0000_00FF_0FFF_FFF0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      we,
  input  logic                      bit_set,
  input  logic                      bit_clr,
  input  logic [$clog2(DATA_W)-1:0] bit_idx,
  input  logic [DATA_W-1:0]         ro_mask,
  output logic [DATA_W-1:0]         rdata,
  output logic [DATA_W-1:0]         eff_addr,
  output logic [DATA_W-1:0]         ptr0,
  output logic [DATA_W-1:0]         ptr1,
  output logic [DATA_W-1:0]         acc
);
  localparam int unsigned ADDR_W = DATA_W;
  localparam int unsigned SFR_AW = $clog2(GP_BASE);
  localparam int unsigned DEPTH  = (1 << ADDR_W) - GP_BASE;
  localparam int unsigned RAM_AW = $clog2(DEPTH);
  localparam logic [GP_BASE-1:0] FIX_ON  = GP_BASE'(42);
  localparam logic [GP_BASE-1:0] FIX_OFF = GP_BASE'(5);
  localparam logic [GP_BASE-1:0] IMPL    = (SFR_MAP | FIX_ON) & ~FIX_OFF;

  logic [DATA_W-1:0] eff, cur, nb, sfr_rd, ram_rd, bmask;
  logic [SFR_AW-1:0] sfr_idx;
  logic [RAM_AW-1:0] ram_idx;
  region_e           region;
  logic              commit, sfr_we, ram_we;

  dm_addr_resolve #(.DATA_W(DATA_W), .GP_BASE(GP_BASE), .IMPL(IMPL)) u_res (
    .addr(addr), .ptr0(ptr0), .ptr1(ptr1), .eff(eff), .region(region)
  );

  assign sfr_idx = eff[SFR_AW-1:0];
  assign ram_idx = RAM_AW'(eff - ADDR_W'(GP_BASE));

  dm_sfr_file #(.DATA_W(DATA_W), .GP_BASE(GP_BASE), .IMPL(IMPL)) u_sfr (
    .clk(clk), .rst_n(rst_n), .rd_idx(sfr_idx), .rd_data(sfr_rd),
    .wr_en(sfr_we), .wr_idx(sfr_idx), .wr_data(nb),
    .ptr0(ptr0), .ptr1(ptr1), .acc(acc)
  );

  dm_gp_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rd_idx(ram_idx), .rd_data(ram_rd),
    .wr_en(ram_we), .wr_idx(ram_idx), .wr_data(nb)
  );

  always_comb begin
    unique case (region)
      RG_SFR:  cur = sfr_rd;
      RG_GPR:  cur = ram_rd;
      default: cur = '0;
    endcase
  end

  assign bmask = (DATA_W'(1) << bit_idx) & ~ro_mask;

  always_comb begin
    if (we)           nb = (cur & ro_mask) | (wdata & ~ro_mask);
    else if (bit_set) nb = cur | bmask;
    else              nb = cur & ~bmask;
  end

  assign commit   = (we || bit_set || bit_clr) && (region == RG_SFR || region == RG_GPR);
  assign sfr_we   = commit && region == RG_SFR;
  assign ram_we   = commit && region == RG_GPR;
  assign rdata    = cur;
  assign eff_addr = eff;

  // R2: a null target leaves pointers and accumulator untouched
  a_r2_null_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_NULL) |=> ($stable(ptr0) && $stable(ptr1) && $stable(acc)));
  // R10: masked accumulator bits survive any committed update
  a_r10_ro_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && region == RG_SFR && eff == ADDR_W'(ACC_A))
    |=> ((acc ^ $past(cur)) & $past(ro_mask)) == '0);
  // R6: a bit operation on the accumulator flips at most one bit
  a_r6_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && (bit_set || bit_clr) && eff == ADDR_W'(ACC_A))
    |=> $countones(acc ^ $past(acc)) <= 1);
  // R4: reserved holes never read back nonzero
  a_r4_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_RSV) |-> rdata == '0);
endmodule

// File: tb/tb_dm_banked_mem.sv
module tb_dm_banked_mem;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, ro_mask = '0;
  logic       we = 1'b0, bit_set = 1'b0, bit_clr = 1'b0;
  logic [2:0] bit_idx = '0;
  logic [7:0] rdata, eff_addr, ptr0, ptr1, acc;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] r;
    logic [7:0] e;
    string      tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] model [256];

  always #10 clk = ~clk;

  dm_banked_mem dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
    .bit_set(bit_set), .bit_clr(bit_clr), .bit_idx(bit_idx), .ro_mask(ro_mask),
    .rdata(rdata), .eff_addr(eff_addr), .ptr0(ptr0), .ptr1(ptr1), .acc(acc)
  );

  function automatic logic [7:0] eff_of(input logic [7:0] a);
    if (a == 8'h00) return model[1];
    if (a == 8'h02) return model[3];
    return a;
  endfunction

  function automatic logic is_store(input logic [7:0] e);
    if (e >= 8'h40) return 1'b1;
    return (e == 8'h01) || (e == 8'h03) || (e >= 8'h04 && e <= 8'h1B) ||
           (e >= 8'h20 && e <= 8'h27);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [7:0] a, input logic [7:0] d, input logic w,
                    input logic s, input logic c, input logic [2:0] b,
                    input logic [7:0] ro);
    logic [7:0] e, cur, nb, m;
    @(negedge clk);
    addr = a; wdata = d; we = w; bit_set = s; bit_clr = c; bit_idx = b; ro_mask = ro;
    e   = eff_of(a);
    cur = is_store(e) ? model[e] : 8'h00;
    m   = (8'h01 << b) & ~ro;
    if (w)      nb = (cur & ro) | (d & ~ro);
    else if (s) nb = cur | m;
    else        nb = cur & ~m;
    if (is_store(e) && (w || s || c)) model[e] = nb;
    @(posedge clk);
    #1;
    we = 1'b0; bit_set = 1'b0; bit_clr = 1'b0; ro_mask = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    op(a, d, 1'b1, 1'b0, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    exp_t it;
    logic [7:0] e;
    @(negedge clk);
    addr = a;
    #2;
    e = eff_of(a);
    it.r = is_store(e) ? model[e] : 8'h00;
    it.e = e;
    it.tag = tag;
    sb.push_back(it);
    #4;
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      wait (sb.size() != 0);
      #1;
      it = sb.pop_front();
      chk({it.tag, " rdata"}, rdata, it.r);
      chk({it.tag, " eff_addr"}, eff_addr, it.e);
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 ptr0", ptr0, 8'h00);
    chk("R9 ptr1", ptr1, 8'h00);
    chk("R9 acc", acc, 8'h00);
    rst_n = 1'b1;
    rd(8'h04, "R9 sfr 04");

    // R3: accumulator
    wr(8'h05, 8'hA5);
    chk("R3 acc port", acc, 8'hA5);
    rd(8'h05, "R3 read 05");

    // R8: write visible only after the edge
    @(negedge clk);
    addr = 8'h05; wdata = 8'h11; we = 1'b1;
    #5;
    chk("R8 acc before edge", acc, 8'hA5);
    chk("R8 rdata before edge", rdata, 8'hA5);
    model[5] = 8'h11;
    @(posedge clk);
    #1;
    we = 1'b0;
    chk("R8 acc after edge", acc, 8'h11);
    chk("R8 rdata after edge", rdata, 8'h11);

    // R5: general RAM
    wr(8'h40, 8'h12);
    wr(8'hFF, 8'h34);
    wr(8'h80, 8'h56);
    rd(8'h40, "R5 40");
    rd(8'hFF, "R5 FF");
    rd(8'h80, "R5 80");

    // R4: reserved holes
    wr(8'h1C, 8'hFF);
    rd(8'h1C, "R4 1C");
    op(8'h3F, 8'h00, 1'b0, 1'b1, 1'b0, 3'd2, 8'h00);
    rd(8'h3F, "R4 3F");
    wr(8'h27, 8'h9E);
    rd(8'h27, "R4 last impl 27");

    // R1 / R13: indirection
    wr(8'h01, 8'h80);
    rd(8'h00, "R1 R13 via ptr0");
    wr(8'h00, 8'h77);
    rd(8'h80, "R1 write via ptr0");
    wr(8'h03, 8'hFF);
    chk("R1 ptr1 port", ptr1, 8'hFF);
    rd(8'h02, "R1 R13 via ptr1");

    // R12: pointer reaching the accumulator
    wr(8'h01, 8'h05);
    rd(8'h00, "R12 read acc indirect");
    wr(8'h00, 8'h3C);
    chk("R12 acc via ptr0", acc, 8'h3C);

    // R2: pointer at an indirect address
    wr(8'h01, 8'h00);
    rd(8'h00, "R2 self pointer reads 0");
    wr(8'h00, 8'hAA);
    chk("R2 ptr0 kept", ptr0, 8'h00);
    chk("R2 acc kept", acc, 8'h3C);
    wr(8'h03, 8'h02);
    rd(8'h02, "R2 ptr1 at 02");
    op(8'h02, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 8'h00);
    chk("R2 ptr1 kept after bit op", ptr1, 8'h02);

    // R6: single bit ops
    op(8'h40, 8'h00, 1'b0, 1'b1, 1'b0, 3'd7, 8'h00);
    rd(8'h40, "R6 set bit7 40");
    op(8'h40, 8'h00, 1'b0, 1'b0, 1'b1, 3'd1, 8'h00);
    rd(8'h40, "R6 clr bit1 40");
    op(8'h05, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 8'h00);
    chk("R6 acc bit0", acc, 8'h3D);

    // R7: bit op through an indirect address
    wr(8'h01, 8'h80);
    op(8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 3'd0, 8'h00);
    rd(8'h80, "R7 clr via ptr0");

    // R10: read-only mask
    op(8'h05, 8'hFF, 1'b1, 1'b0, 1'b0, 3'd0, 8'hF0);
    chk("R10 masked write", acc, 8'h3F);
    op(8'h05, 8'h00, 1'b0, 1'b0, 1'b1, 3'd5, 8'h20);
    chk("R10 masked clr", acc, 8'h3F);
    op(8'h05, 8'h00, 1'b0, 1'b0, 1'b1, 3'd4, 8'h20);
    chk("R10 unmasked clr", acc, 8'h2F);

    // R11: strobe priority
    wr(8'h41, 8'hF0);
    op(8'h41, 8'h00, 1'b1, 1'b1, 1'b0, 3'd3, 8'h00);
    rd(8'h41, "R11 write beats set");
    op(8'h41, 8'h00, 1'b0, 1'b1, 1'b1, 3'd2, 8'h00);
    rd(8'h41, "R11 set beats clr");

    // R12: pointer writes itself through indirection
    wr(8'h01, 8'h01);
    wr(8'h00, 8'h90);
    chk("R12 ptr0 self write", ptr0, 8'h90);

    wait (sb.size() == 0);
    #5;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule